// File: doc/BRIEF.md
# Control Endpoint Receive Status with Two-Deep Holding

This block keeps the receive status that firmware reads back after each packet arrives on a bidirectional control endpoint. The receive path reports each end-of-packet with one strobe. The strobe carries whether the packet was a SETUP, the data toggle it arrived with, and its byte count. The block formats these into an 8-bit status word. The word sits on a read port, and firmware takes it with a one-cycle read strobe.

A control transfer can end with a zero-length OUT or SETUP packet and then be followed at once by a new SETUP packet with data. Two status copies are therefore kept, so firmware sees the zero-length status on its first read and the SETUP status on its second read, and neither is lost. A read consumes the copy on the port. Its flags go to zero, or the younger copy moves forward into view. A third packet that arrives while both copies are occupied replaces the younger copy and sets a sticky overrun output.

Top module: `ep0_rx_stat_dbuf`

## Requirements
- R1: While `rst_n` is low at a clock edge, both copies, all flags and `overrun` clear, so that `rd_data` reads 0x00 and `overrun` reads 0 after that edge.
- R2: With nothing pending, an end-of-packet event makes `rd_data` show, from the next cycle on, bit 6 = setup flag, bit 5 = toggle, bit 4 = last-packet flag (1), and bits 3..0 = byte count.
- R3: A reported byte count above `MAX_CNT` (8) is stored and shown as 8. The count field never shows more than 8.
- R4: A read strobe with exactly one status pending and no event in that cycle clears bits 6..4 on the cycle after. The count in bits 3..0 is kept.
- R5: With two statuses pending, `rd_data` shows the older one. After a read strobe, the newer one is shown unchanged.
- R6: A zero-length packet followed by a SETUP packet reads first as last-packet 1 with count 0, and then as the SETUP status with setup flag 1.
- R7: An event while both copies are occupied and no read strobe is present replaces the newer copy, leaves the older copy on `rd_data`, and sets `overrun`.
- R8: Once set, `overrun` stays set until reset, whatever reads and events follow.
- R9: A read strobe and an event in the same cycle are ordered read first. With one pending, the new status is shown next. With two pending, the newer copy is shown next and the new status queues behind it, without overrun.
- R10: Bit 7 of `rd_data` always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eop_valid | input | 1 | One-cycle end-of-packet event from the receive path |
| eop_setup | input | 1 | Packet was a SETUP |
| eop_toggle | input | 1 | Data toggle of the packet |
| eop_count | input | 4 | Byte count of the packet |
| rd_stb | input | 1 | Firmware read strobe; consumes the status on `rd_data` |
| rd_data | output | 8 | Visible status word |
| overrun | output | 1 | Sticky: a status was lost while both copies were occupied |

## Verification
The bench sweeps every setup, toggle and count combination through a capture-and-read cycle. Counts 9 to 15 are included, so a design that forgets to clamp shows a count above 8, and one that clears the count on read loses the FIFO level. Pairs of packets with complementary counts check the ordering, since a design that overwrote the older copy or promoted too early would show the second status first. The overrun path and the same-cycle read-and-event cases are checked as well. In these cases a wrong ordering either drops a status or raises `overrun` when no status was lost.

// File: rtl/rxs_pkg.sv
// Shared types for the control-endpoint receive status block.
// Assumes a 4-bit count field; the status word is 3 flags plus the count plus a zero top bit.
package rxs_pkg;
    parameter int unsigned CNT_W  = 4;
    localparam int unsigned DATA_W = CNT_W + 4;

    typedef struct packed {
        logic             setup;
        logic             toggle;
        logic             last;
        logic [CNT_W-1:0] cnt;
    } rxs_stat_t;

    typedef enum logic [1:0] {
        OCC_NONE = 2'd0,
        OCC_ONE  = 2'd1,
        OCC_TWO  = 2'd2
    } rxs_occ_t;

    // Formats a stored status into the visible word with a zero top bit.
    function automatic logic [DATA_W-1:0] rxs_word(input rxs_stat_t s);
        return {1'b0, s};
    endfunction
endpackage

// File: rtl/rxs_capture.sv
// Turns an end-of-packet event into a status record.
// Assumes the event fields are valid whenever the event strobe is high.
// The last-packet flag is always set, and the count saturates at MAX_CNT.
module rxs_capture
    import rxs_pkg::*;
#(
    parameter int unsigned MAX_CNT = 8
) (
    input  logic             ev_setup,
    input  logic             ev_toggle,
    input  logic [CNT_W-1:0] ev_cnt,
    output rxs_stat_t        stat
);
    localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(MAX_CNT);

    // Build the record, clamping the count to the endpoint's packet size.
    always_comb begin
        stat.setup  = ev_setup;
        stat.toggle = ev_toggle;
        stat.last   = 1'b1;
        stat.cnt    = (ev_cnt > CNT_CAP) ? CNT_CAP : ev_cnt;
    end
endmodule

// File: rtl/rxs_slot.sv
// One status copy. A load takes priority over a flag clear.
// A flag clear zeroes setup, toggle and last, and keeps the count.
module rxs_slot
    import rxs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  rxs_stat_t din,
    input  logic      clr_flags,
    output rxs_stat_t q
);
    // Hold, load or clear the flags of the stored status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end else if (clr_flags) begin
            q.setup  <= 1'b0;
            q.toggle <= 1'b0;
            q.last   <= 1'b0;
        end
    end
endmodule

// File: rtl/rxs_ctrl.sv
// Occupancy control for the two status copies.
// A read in the same cycle as an event is taken first.
// A third event while both copies are occupied replaces the back copy and sets a sticky overrun flag.
module rxs_ctrl
    import rxs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ev,
    input  logic     rd,
    output rxs_occ_t occ,
    output logic     front_load,
    output logic     front_from_back,
    output logic     front_clr,
    output logic     back_load,
    output logic     ovr
);
    rxs_occ_t occ_nx;
    logic     ovr_set;

    // Decide the slot actions and the next occupancy from the current state.
    always_comb begin
        occ_nx          = occ;
        front_load      = 1'b0;
        front_from_back = 1'b0;
        front_clr       = 1'b0;
        back_load       = 1'b0;
        ovr_set         = 1'b0;
        unique case (occ)
            OCC_NONE: begin
                if (ev) begin
                    front_load = 1'b1;
                    occ_nx     = OCC_ONE;
                end else if (rd) begin
                    front_clr = 1'b1;
                end
            end
            OCC_ONE: begin
                if (ev && rd) begin
                    front_load = 1'b1;
                end else if (ev) begin
                    back_load = 1'b1;
                    occ_nx    = OCC_TWO;
                end else if (rd) begin
                    front_clr = 1'b1;
                    occ_nx    = OCC_NONE;
                end
            end
            OCC_TWO: begin
                if (rd) begin
                    front_load      = 1'b1;
                    front_from_back = 1'b1;
                    back_load       = ev;
                    occ_nx          = ev ? OCC_TWO : OCC_ONE;
                end else if (ev) begin
                    back_load = 1'b1;
                    ovr_set   = 1'b1;
                end
            end
            default: occ_nx = OCC_NONE;
        endcase
    end

    // Register the occupancy and the sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= OCC_NONE;
            ovr <= 1'b0;
        end else begin
            occ <= occ_nx;
            ovr <= ovr | ovr_set;
        end
    end
endmodule

// File: rtl/ep0_rx_stat_dbuf.sv
// Top level: receive status for a control endpoint, two copies deep.
// The front copy drives rd_data, and the back copy holds the next status.
// Assumes rd_stb and eop_valid are one-cycle pulses in the clk domain.
module ep0_rx_stat_dbuf
    import rxs_pkg::*;
#(
    parameter int unsigned MAX_CNT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eop_valid,
    input  logic              eop_setup,
    input  logic              eop_toggle,
    input  logic [CNT_W-1:0]  eop_count,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              overrun
);
    rxs_stat_t cap_stat, front_q, back_q, front_din;
    rxs_occ_t  occ;
    logic      front_load, front_from_back, front_clr, back_load;

    rxs_capture #(.MAX_CNT(MAX_CNT)) u_cap (
        .ev_setup (eop_setup),
        .ev_toggle(eop_toggle),
        .ev_cnt   (eop_count),
        .stat     (cap_stat)
    );

    rxs_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev             (eop_valid),
        .rd             (rd_stb),
        .occ            (occ),
        .front_load     (front_load),
        .front_from_back(front_from_back),
        .front_clr      (front_clr),
        .back_load      (back_load),
        .ovr            (overrun)
    );

    // Pick the front copy's source: a promotion from the back copy or a new capture.
    always_comb front_din = front_from_back ? back_q : cap_stat;

    rxs_slot u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (front_load),
        .din      (front_din),
        .clr_flags(front_clr),
        .q        (front_q)
    );

    rxs_slot u_back (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (back_load),
        .din      (cap_stat),
        .clr_flags(1'b0),
        .q        (back_q)
    );

    // Present the front copy as the status word.
    always_comb rd_data = rxs_word(front_q);
endmodule

// File: rtl/ep0_rx_stat_dbuf_chk.sv
// Checker bound into ep0_rx_stat_dbuf. It watches the ports and the occupancy state.
module ep0_rx_stat_dbuf_chk
    import rxs_pkg::*;
#(
    parameter int unsigned MAX_CNT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eop_valid,
    input logic              rd_stb,
    input logic [DATA_W-1:0] rd_data,
    input logic              overrun,
    input rxs_occ_t          occ
);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && !overrun));

    a_r10_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1] == 1'b0);

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[CNT_W-1:0] <= CNT_W'(MAX_CNT));

    a_r2_last_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_valid && (occ == OCC_NONE || (rd_stb && occ == OCC_ONE))) |=> rd_data[4]);

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !eop_valid && occ != OCC_TWO) |=> rd_data[6:4] == 3'b000);

    a_r7_overrun_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_valid && !rd_stb && occ == OCC_TWO) |=> overrun);

    a_r7_older_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_valid && !rd_stb && occ == OCC_TWO) |=> $stable(rd_data));

    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

bind ep0_rx_stat_dbuf ep0_rx_stat_dbuf_chk #(.MAX_CNT(MAX_CNT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .eop_valid(eop_valid),
    .rd_stb   (rd_stb),
    .rd_data  (rd_data),
    .overrun  (overrun),
    .occ      (occ)
);

// File: tb/ep0_rx_stat_dbuf_test.sv
module ep0_rx_stat_dbuf_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       eop_valid = 1'b0, eop_setup = 1'b0, eop_toggle = 1'b0;
    logic [3:0] eop_count = '0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       overrun;
    int         n_chk = 0, n_bad = 0;

    ep0_rx_stat_dbuf uut (
        .clk(clk), .rst_n(rst_n), .eop_valid(eop_valid), .eop_setup(eop_setup),
        .eop_toggle(eop_toggle), .eop_count(eop_count), .rd_stb(rd_stb),
        .rd_data(rd_data), .overrun(overrun)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] word(input logic s, input logic t, input logic l, input int c);
        int cc = (c > 8) ? 8 : c;
        return {1'b0, s, t, l, 4'(cc)};
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic send(input logic s, input logic t, input int c);
        eop_valid = 1'b1; eop_setup = s; eop_toggle = t; eop_count = 4'(c);
        tick();
        eop_valid = 1'b0;
    endtask

    task automatic rd();
        rd_stb = 1'b1;
        tick();
        rd_stb = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 reset word", rd_data, 8'h00);
        chk("R1 reset overrun", {7'b0, overrun}, 8'h00);

        // R2/R3/R4: sweep every setup, toggle and count through capture and read
        for (int s = 0; s < 2; s++)
            for (int t = 0; t < 2; t++)
                for (int c = 0; c < 16; c++) begin
                    send(s[0], t[0], c);
                    chk(c > 8 ? "R3 clamp" : "R2 capture", rd_data, word(s[0], t[0], 1'b1, c));
                    chk("R10 bit7", {7'b0, rd_data[7]}, 8'h00);
                    rd();
                    chk("R4 flags cleared", rd_data, word(1'b0, 1'b0, 1'b0, c));
                end

        // R5: two pending, older first, then the newer promoted
        for (int c = 0; c < 16; c++) begin
            send(1'b0, c[0], c);
            send(1'b1, ~c[0], 15 - c);
            chk("R5 older shown", rd_data, word(1'b0, c[0], 1'b1, c));
            rd();
            chk("R5 newer promoted", rd_data, word(1'b1, ~c[0], 1'b1, 15 - c));
            rd();
            chk("R5 drained", rd_data, word(1'b0, 1'b0, 1'b0, 15 - c));
        end
        chk("R5 no overrun", {7'b0, overrun}, 8'h00);

        // R6: zero-length then SETUP with data
        send(1'b0, 1'b1, 0);
        send(1'b1, 1'b0, 8);
        chk("R6 zero-length first", rd_data, 8'h30);
        rd();
        chk("R6 setup second", rd_data, 8'h58);
        rd();

        // R9: read and event in the same cycle, one pending
        send(1'b0, 1'b0, 3);
        eop_valid = 1'b1; eop_setup = 1'b1; eop_toggle = 1'b1; eop_count = 4'd5; rd_stb = 1'b1;
        tick();
        eop_valid = 1'b0; rd_stb = 1'b0;
        chk("R9 one pending new shown", rd_data, word(1'b1, 1'b1, 1'b1, 5));
        // R9: two pending
        send(1'b0, 1'b0, 1);
        eop_valid = 1'b1; eop_setup = 1'b0; eop_toggle = 1'b1; eop_count = 4'd7; rd_stb = 1'b1;
        tick();
        eop_valid = 1'b0; rd_stb = 1'b0;
        chk("R9 two pending newer shown", rd_data, word(1'b0, 1'b0, 1'b1, 1));
        rd();
        chk("R9 queued new", rd_data, word(1'b0, 1'b1, 1'b1, 7));
        chk("R9 no overrun", {7'b0, overrun}, 8'h00);
        rd();

        // R7: third event replaces the newer copy
        send(1'b1, 1'b0, 2);
        send(1'b0, 1'b1, 4);
        send(1'b0, 1'b0, 6);
        chk("R7 older kept", rd_data, word(1'b1, 1'b0, 1'b1, 2));
        chk("R7 overrun set", {7'b0, overrun}, 8'h01);
        rd();
        chk("R7 replaced newer", rd_data, word(1'b0, 1'b0, 1'b1, 6));
        rd();

        // R8: sticky until reset
        send(1'b1, 1'b1, 1);
        rd();
        tick();
        chk("R8 overrun sticky", {7'b0, overrun}, 8'h01);
        do_reset();
        chk("R8 overrun cleared by reset", {7'b0, overrun}, 8'h00);
        chk("R1 word after reset", rd_data, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule